// File: doc/BRIEF.md
# 64-bit Interval Timer

This block is a memory-mapped interval timer built around a free-running up-counter that is twice as wide as the register word. The counter is 64 bits wide with the default 32-bit word. Software sets the tick source, a prescaler, the running mode and a 64-bit period, then starts the timer. Each time the count reaches the period, the block sets a status flag. The interrupt line carries that flag when it is enabled. In continuous mode the counter then wraps and keeps running. In one-shot mode it parks at the period until software starts it again.

The counter can be driven from the register clock, with one tick per cycle, or from an external tick strobe. The strobe must toggle at no more than a third of the clock rate, because the block synchronizes it and detects its rising edges. A 4-bit prescaler divides the selected source by 1 to 16. The counter is read as two words. Reading the low word captures the high word in the same cycle, so a later read of the high word completes a consistent 64-bit value however long software waits between the two reads. A software reset bit stops the timer and clears its run state but keeps the configuration.

Top module: `ivtimer64`

## Requirements
- R1: After reset the counter reads 0, the status flag reads 0, irq_o is 0 and the mode register reads 0.
- R2: Register byte addresses are: control 0x00, mode 0x04, period low 0x08, period high 0x0C, interrupt enable 0x10, status 0x1C, counter low 0x20, counter high 0x24. A read is answered with rsp_valid high and the data in the cycle after it is accepted. The mode register reads back as written in bits 0, 3 and 11:8.
- R3: A write of control bit 0 (start) clears the counter to 0 and the prescaler phase, and sets the timer running. The counter then advances by one for each prescaled tick.
- R4: Mode bits 11:8 hold a value P. While the timer runs, the counter advances once every P+1 source ticks.
- R5: Mode bit 3 selects the tick source. With 0, every clock cycle is a tick. With 1, each rising edge of alt_tick_i is a tick after a SYNC_N-stage synchronizer, and the counter does not move while alt_tick_i is idle.
- R6: With mode bit 0 = 1 (continuous), an advance that finds the count equal to the period sets the status flag and returns the count to 0.
- R7: With mode bit 0 = 0 (one-shot), that advance sets the flag and stops the timer with the count held at the period until the next start.
- R8: A write to the period high word is held aside. The full period changes only when the period low word is written.
- R9: Reading status returns the flag in bit 0 and clears it, except when a period event happens in the same cycle, in which case the flag stays set.
- R10: irq_o is high exactly when the status flag and interrupt-enable bit 0 are both set.
- R11: A write of control bit 8 stops the timer and clears the counter, the prescaler phase and the flag. It takes priority over bit 0 in the same write. The mode, period and enable registers keep their values.
- R12: Reading the counter low word captures the current high word. A read of the counter high word returns that captured value, not the live one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_tick_i | input | 1 | Alternate tick strobe, asynchronous, at most a third of the clk rate |
| req_valid | input | 1 | Register access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | DW | Read data |
| irq_o | output | 1 | Period interrupt: status flag AND enable |

## Verification
The hardest case to reach from the ports is a torn counter read, where the low word rolls over between the read of the low word and the read of the high word. The bench therefore builds the block with a 16-bit word, which gives a 32-bit counter. It runs the counter from the clock with no prescaling and waits a computed number of cycles, so that the low-word read lands just below the rollover. It then reads the high word after the rollover has happened and expects the captured 0 rather than the live 1. The case where a period event and a status read fall in the same cycle is reached by programming a period of 0, which makes every advance an event.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // register byte addresses
  localparam logic [7:0] A_CTRL   = 8'h00;
  localparam logic [7:0] A_MODE   = 8'h04;
  localparam logic [7:0] A_PER_LO = 8'h08;
  localparam logic [7:0] A_PER_HI = 8'h0C;
  localparam logic [7:0] A_IEN    = 8'h10;
  localparam logic [7:0] A_STAT   = 8'h1C;
  localparam logic [7:0] A_CNT_LO = 8'h20;
  localparam logic [7:0] A_CNT_HI = 8'h24;
  // bit positions
  localparam int unsigned B_START  = 0;
  localparam int unsigned B_SWRST  = 8;
  localparam int unsigned B_CONT   = 0;
  localparam int unsigned B_ALT    = 3;
  localparam int unsigned B_PSC_LO = 8;
  typedef enum logic {SRC_CLK = 1'b0, SRC_ALT = 1'b1} src_e;
endpackage

// File: rtl/ivt_tick_gen.sv
module ivt_tick_gen #(
  parameter int unsigned PSC_W  = 4,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             alt_tick_i,
  input  ivt_pkg::src_e    src,
  input  logic [PSC_W-1:0] psc_val,
  output logic             adv
);
  logic [SYNC_N-1:0] sync_q;
  logic              last_q;
  logic [PSC_W-1:0]  phase_q;
  logic              alt_edge, src_tick, wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], alt_tick_i};
      last_q <= sync_q[SYNC_N-1];
    end
  end

  assign alt_edge = sync_q[SYNC_N-1] & ~last_q;
  assign src_tick = (src == ivt_pkg::SRC_ALT) ? alt_edge : 1'b1;
  assign wrap     = (phase_q >= psc_val);
  assign adv      = run & src_tick & wrap;

  always_ff @(posedge clk) begin
    if (rst || clr)
      phase_q <= '0;
    else if (run && src_tick)
      phase_q <= wrap ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int unsigned CW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          start,
  input  logic          adv,
  input  logic          cont,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] cnt,
  output logic          running,
  output logic          evt
);
  logic [CW-1:0] cnt_q;
  logic          run_q, at_end;

  assign at_end  = (cnt_q == period);
  assign evt     = run_q & adv & at_end & ~start & ~clr;
  assign cnt     = cnt_q;
  assign running = run_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q && adv) begin
      if (at_end) begin
        if (cont) cnt_q <= '0;
        run_q <= cont;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ivtimer64.sv
module ivtimer64 #(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned PSC_W  = 4,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alt_tick_i,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              irq_o
);
  import ivt_pkg::*;
  localparam int unsigned CW = 2 * DW;

  logic             cont_q;
  src_e             src_q;
  logic [PSC_W-1:0] psc_q;
  logic [CW-1:0]    per_q;
  logic [DW-1:0]    per_hi_stage_q, snap_hi_q, rd_mux;
  logic             ien_q, flag_q;
  logic             wr, rd, swrst, start, adv_w, run_w, evt_w;
  logic [CW-1:0]    cnt_w;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] r);
    return a == ADDR_W'(r);
  endfunction

  assign wr    = req_valid & req_write;
  assign rd    = req_valid & ~req_write;
  assign swrst = wr & hit(req_addr, A_CTRL) & req_wdata[B_SWRST];
  assign start = wr & hit(req_addr, A_CTRL) & req_wdata[B_START] & ~swrst;

  ivt_tick_gen #(.PSC_W(PSC_W), .SYNC_N(SYNC_N)) u_tick (
    .clk(clk), .rst(rst), .clr(swrst | start), .run(run_w),
    .alt_tick_i(alt_tick_i), .src(src_q), .psc_val(psc_q), .adv(adv_w)
  );

  ivt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .clr(swrst), .start(start), .adv(adv_w),
    .cont(cont_q), .period(per_q), .cnt(cnt_w), .running(run_w), .evt(evt_w)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cont_q         <= 1'b0;
      src_q          <= SRC_CLK;
      psc_q          <= '0;
      per_q          <= '0;
      per_hi_stage_q <= '0;
      ien_q          <= 1'b0;
    end else if (wr) begin
      if (hit(req_addr, A_MODE)) begin
        cont_q <= req_wdata[B_CONT];
        src_q  <= src_e'(req_wdata[B_ALT]);
        psc_q  <= req_wdata[B_PSC_LO +: PSC_W];
      end
      if (hit(req_addr, A_PER_HI)) per_hi_stage_q <= req_wdata;
      if (hit(req_addr, A_PER_LO)) per_q <= {per_hi_stage_q, req_wdata};
      if (hit(req_addr, A_IEN))    ien_q <= req_wdata[0];
    end
  end

  // status flag: a same-cycle event wins over the clearing read
  always_ff @(posedge clk) begin
    if (rst || swrst)                       flag_q <= 1'b0;
    else if (evt_w)                         flag_q <= 1'b1;
    else if (rd && hit(req_addr, A_STAT))   flag_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (hit(req_addr, A_MODE)) begin
      rd_mux[B_CONT]              = cont_q;
      rd_mux[B_ALT]               = (src_q == SRC_ALT);
      rd_mux[B_PSC_LO +: PSC_W]   = psc_q;
    end else if (hit(req_addr, A_PER_LO)) rd_mux = per_q[DW-1:0];
    else if (hit(req_addr, A_PER_HI))     rd_mux = per_q[CW-1:DW];
    else if (hit(req_addr, A_IEN))        rd_mux[0] = ien_q;
    else if (hit(req_addr, A_STAT))       rd_mux[0] = flag_q;
    else if (hit(req_addr, A_CNT_LO))     rd_mux = cnt_w[DW-1:0];
    else if (hit(req_addr, A_CNT_HI))     rd_mux = snap_hi_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      snap_hi_q <= '0;
    end else begin
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rd_mux;
      if (rd && hit(req_addr, A_CNT_LO)) snap_hi_q <= cnt_w[CW-1:DW];
    end
  end

  assign irq_o = flag_q & ien_q;
endmodule

// File: rtl/ivt_checker.sv
module ivt_checker #(
  parameter int unsigned DW     = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DW-1:0]     req_wdata,
  input logic              rsp_valid,
  input logic              irq_o,
  input logic [2*DW-1:0]   cnt,
  input logic              running,
  input logic              cont,
  input logic              flag,
  input logic              evt
);
  logic is_rd, is_swrst, is_stat_rd;
  assign is_rd      = req_valid & ~req_write;
  assign is_swrst   = req_valid & req_write & (req_addr == ADDR_W'(ivt_pkg::A_CTRL)) & req_wdata[8];
  assign is_stat_rd = is_rd & (req_addr == ADDR_W'(ivt_pkg::A_STAT));

  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (cnt == '0 && !flag && !rsp_valid && !irq_o));

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (rst)
    is_rd |=> rsp_valid);

  p_rsp_only_read_r2: assert property (@(posedge clk) disable iff (rst)
    !is_rd |=> !rsp_valid);

  p_cont_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (evt && cont) |=> (cnt == '0 && flag && running));

  p_oneshot_halt_r7: assert property (@(posedge clk) disable iff (rst)
    (evt && !cont) |=> (!running && flag && cnt == $past(cnt)));

  p_status_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (is_stat_rd && !evt) |=> !flag);

  p_swrst_r11: assert property (@(posedge clk) disable iff (rst)
    is_swrst |=> (cnt == '0 && !running && !flag && !irq_o));
endmodule

bind ivtimer64 ivt_checker #(.DW(DW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .irq_o(irq_o), .cnt(cnt_w), .running(run_w), .cont(cont_q),
  .flag(flag_q), .evt(evt_w)
);

// File: tb/sim_ivtimer64.sv
`timescale 1ns/1ps
module sim_ivtimer64;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          alt_tick_i = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          irq_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ivtimer64 #(.DW(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .alt_tick_i(alt_tick_i), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
  );

  localparam logic [AW-1:0] CTRL = 6'h00, MODE = 6'h04, PLO = 6'h08, PHI = 6'h0C,
                            IEN = 6'h10, STAT = 6'h1C, CLO = 6'h20, CHI = 6'h24;

  task automatic chk(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 rsp_valid", longint'(rsp_valid), 1);
    d = rsp_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    chk("R1 irq after reset", longint'(irq_o), 0);
    rd(CLO, v);  chk("R1 counter low", longint'(v), 0);
    rd(STAT, v); chk("R1 status", longint'(v), 0);
    rd(MODE, v); chk("R1 mode", longint'(v), 0);
  endtask

  task automatic t_regs;
    logic [DW-1:0] v;
    wr(MODE, 16'h0309);
    rd(MODE, v); chk("R2 mode readback", longint'(v), 16'h0309);
    wr(IEN, 16'h0001);
    rd(IEN, v);  chk("R2 enable readback", longint'(v), 1);
  endtask

  task automatic t_count_clk;
    logic [DW-1:0] v;
    wr(PHI, 16'hFFFF); wr(PLO, 16'hFFFF);
    wr(MODE, 16'h0001);
    wr(CTRL, 16'h0001);
    idle(10);
    rd(CLO, v); chk("R3 count per clock", longint'(v), 11);
  endtask

  task automatic t_prescale;
    logic [DW-1:0] v;
    wr(MODE, 16'h0301);
    wr(CTRL, 16'h0001);
    idle(20);
    rd(CLO, v); chk("R4 prescale by 4", longint'(v), 5);
  endtask

  task automatic t_cont_wrap;
    logic [DW-1:0] v;
    wr(CTRL, 16'h0100);
    wr(PHI, 16'h0000); wr(PLO, 16'h0003);
    wr(MODE, 16'h0001); wr(IEN, 16'h0001);
    wr(CTRL, 16'h0001);
    idle(10);
    rd(CLO, v); chk("R6 wrapped count", longint'(v), 3);
    chk("R10 irq with flag and enable", longint'(irq_o), 1);
    rd(STAT, v); chk("R9 status set", longint'(v), 1);
  endtask

  task automatic t_oneshot;
    logic [DW-1:0] v;
    wr(CTRL, 16'h0100);
    wr(PLO, 16'h0005);
    wr(MODE, 16'h0000);
    wr(CTRL, 16'h0001);
    idle(30);
    rd(CLO, v);  chk("R7 held at period", longint'(v), 5);
    rd(STAT, v); chk("R7 flag after one-shot", longint'(v), 1);
    rd(STAT, v); chk("R9 status cleared by read", longint'(v), 0);
    chk("R10 irq low after clear", longint'(irq_o), 0);
    wr(PHI, 16'h0001);
    wr(CTRL, 16'h0001);
    idle(30);
    rd(CLO, v); chk("R8 high write alone no effect", longint'(v), 5);
    rd(CHI, v); chk("R8 high word of count", longint'(v), 0);
    wr(CTRL, 16'h0001);
    idle(1);
    rd(CLO, v); chk("R7 restart from zero", longint'(v), 2);
    wr(PHI, 16'h0000); wr(PLO, 16'h0005);
  endtask

  task automatic t_same_cycle;
    logic [DW-1:0] v;
    wr(CTRL, 16'h0100);
    wr(PLO, 16'h0000);
    wr(MODE, 16'h0001);
    wr(IEN, 16'h0000);
    wr(CTRL, 16'h0001);
    idle(5);
    rd(STAT, v); chk("R9 status with event", longint'(v), 1);
    rd(STAT, v); chk("R9 event beats clearing read", longint'(v), 1);
    chk("R10 irq masked when disabled", longint'(irq_o), 0);
    wr(IEN, 16'h0001);
    idle(1);
    chk("R10 irq when enabled", longint'(irq_o), 1);
  endtask

  task automatic t_swrst;
    logic [DW-1:0] v;
    wr(CTRL, 16'h0101);
    idle(5);
    chk("R11 irq after sw reset", longint'(irq_o), 0);
    rd(CLO, v);  chk("R11 counter cleared and stopped", longint'(v), 0);
    rd(STAT, v); chk("R11 flag cleared", longint'(v), 0);
    rd(MODE, v); chk("R11 mode kept", longint'(v), 16'h0001);
    wr(CTRL, 16'h0001);
    idle(5);
    rd(STAT, v); chk("R11 period kept, events resume", longint'(v), 1);
  endtask

  task automatic t_alt_src;
    logic [DW-1:0] v;
    wr(CTRL, 16'h0100);
    wr(PHI, 16'hFFFF); wr(PLO, 16'hFFFF);
    wr(MODE, 16'h0009);
    wr(CTRL, 16'h0001);
    idle(10);
    rd(CLO, v); chk("R5 idle strobe no advance", longint'(v), 0);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); alt_tick_i = 1'b1;
      idle(3);        alt_tick_i = 1'b0;
      idle(3);
    end
    idle(10);
    rd(CLO, v); chk("R5 one advance per strobe edge", longint'(v), 7);
  endtask

  task automatic t_tear;
    logic [DW-1:0] v;
    wr(CTRL, 16'h0100);
    wr(PHI, 16'hFFFF); wr(PLO, 16'hFFFF);
    wr(MODE, 16'h0001);
    wr(CTRL, 16'h0001);
    idle(65529);
    rd(CLO, v); chk("R3 low word near rollover", longint'(v), 16'hFFFA);
    idle(20);
    rd(CHI, v); chk("R12 high word captured with low", longint'(v), 0);
    rd(CLO, v);
    rd(CHI, v); chk("R12 high word after rollover", longint'(v), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_count_clk();
    t_prescale();
    t_cont_wrap();
    t_oneshot();
    t_same_cycle();
    t_swrst();
    t_alt_src();
    t_tear();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule